// File: doc/BRIEF.md
# Threshold Byte FIFO with Access Error Flags

This block is a byte-wide FIFO placed between a register-mapped data port and a transfer sequencer. Software pushes bytes to be transmitted and pops bytes that were received. The sequencer pushes received bytes and pops bytes to transmit. The depth is a parameter and may be 8, 16, 32 or 64 entries. A separate level counter tells a full FIFO from an empty one. The read and write pointers wrap modulo the depth.

Misuse does not wrap or corrupt the FIFO. A software read of an empty FIFO and a software write to a full FIFO both raise an access-error flag. A sequencer push into a full FIFO raises a receive-overrun flag, and a sequencer pop from an empty FIFO raises a transmit-underflow flag. After every software pop, the receive-ready and receive-drain flags are set again by comparing the remaining level with a programmable threshold. A sequencer push sets them the same way.

A configuration write can flush the FIFO. A buffer-status word reports the depth code, the fill level and the low bits of a remaining-count input. A legacy mode moves two bytes per software access, with selectable byte order. In that mode, a read that finds only one byte sets an odd-byte flag.

Top module: `thresh_byte_fifo`

## Requirements
- R1: When the FIFO is not full, a software write outside legacy mode pushes `sw_wdata[7:0]` and clears status bit 7 (access error). When the FIFO is full, the write sets bit 7, drops the data and leaves the level unchanged.
- R2: A software read of an empty FIFO returns 0 on `sw_rdata` and sets status bit 7. A read of a non-empty FIFO returns the oldest byte in `sw_rdata[7:0]`, with the upper byte 0, and clears bits 7 and 11 (receive overrun).
- R3: After a software pop, if entries remain and the new level is at or below the threshold, bit 3 (receive ready) is cleared and bit 13 (receive drain) is set. If the pop leaves the FIFO empty, bits 3 and 13 are cleared and bit 2 (access ready) is set.
- R4: A sequencer push into a FIFO that is not full stores `seq_wdata`. If the new level is above the threshold, it sets bit 3 and clears bit 13; otherwise it sets bit 13 and clears bit 3. A push into a full FIFO sets bit 11 and drops the byte.
- R5: A sequencer pop returns the oldest byte on `seq_rdata`. A pop of an empty FIFO returns 0 and sets bit 10 (transmit underflow). Any software data write clears bit 10.
- R6: A configuration write loads the receive threshold from `cfg_wdata[13:8]`. If `cfg_wdata[14]` or `cfg_wdata[6]` is set, the write also empties the FIFO.
- R7: `bufstat` holds the depth code in bits 15:14 (8→0, 16→1, 32→2, 64→3), the level in bits 13:8 and `remain_count[5:0]` in bits 5:0. Bits 7:6 are 0.
- R8: In legacy mode, a software write pushes two bytes: `sw_wdata[15:8]` first when `byte_order_hi` is 1, and `sw_wdata[7:0]` first otherwise. The write is ignored when more than two bytes are already held.
- R9: In legacy mode, a software read pops two bytes and returns them in the same order: the older byte goes in bits 15:8 when `byte_order_hi` is 1, and in bits 7:0 otherwise. If only one byte is held, the missing byte reads as 0, status bit 15 (odd byte) is set and the FIFO empties.
- R10: A push and a pop in the same cycle leave the level unchanged. Byte order is preserved across pointer wrap.
- R11: Each bit set in `stat_clr` clears that status bit. An event that sets a bit in the same cycle takes precedence.
- R12: After reset the FIFO is empty, all status bits are 0 and the threshold is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| legacy_mode | input | 1 | Two bytes per software access |
| byte_order_hi | input | 1 | Legacy order: high byte is the older byte |
| sw_wr | input | 1 | Software data write |
| sw_wdata | input | 16 | Software write data |
| sw_rd | input | 1 | Software data read (pop) |
| sw_rdata | output | 16 | Software read data, valid in the cycle of `sw_rd` |
| seq_push | input | 1 | Sequencer push (software write has priority) |
| seq_wdata | input | 8 | Sequencer push byte |
| seq_pop | input | 1 | Sequencer pop (software read has priority) |
| seq_rdata | output | 8 | Oldest byte, 0 when empty |
| cfg_wr | input | 1 | Configuration write |
| cfg_wdata | input | 16 | Threshold and flush bits |
| stat_clr | input | 16 | Write-one-to-clear mask for status |
| remain_count | input | 16 | Remaining transfer count from the sequencer |
| status | output | 16 | Flags: bits 2, 3, 7, 10, 11, 13, 15 |
| bufstat | output | 16 | Depth code, level and remaining count |

## Verification
The main instance of the bench uses a depth of 8. At that depth, filling to full, overflowing and wrapping the pointers several times all take only a few cycles, and the full-level value 8 is visible in the level field. A second instance with a depth of 64 checks the largest depth code. Threshold 3 is programmed at depth 8, so pushes and pops cross the ready/drain boundary in both directions.

// File: rtl/thresh_byte_fifo.sv
module thresh_byte_fifo #(
  parameter int DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        legacy_mode,
  input  logic        byte_order_hi,
  input  logic        sw_wr,
  input  logic [15:0] sw_wdata,
  input  logic        sw_rd,
  output logic [15:0] sw_rdata,
  input  logic        seq_push,
  input  logic [7:0]  seq_wdata,
  input  logic        seq_pop,
  output logic [7:0]  seq_rdata,
  input  logic        cfg_wr,
  input  logic [15:0] cfg_wdata,
  input  logic [15:0] stat_clr,
  input  logic [15:0] remain_count,
  output logic [15:0] status,
  output logic [15:0] bufstat
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH + 1);
  localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);
  localparam logic [1:0] DCODE = 2'(AW - 3);
  localparam int F_DONE = 2, F_RXRDY = 3, F_AERR = 7, F_TXUF = 10;
  localparam int F_RXOV = 11, F_DRAIN = 13, F_ODD = 15;
  localparam logic [15:0] USED = 16'hAC8C;

  initial begin
    assert (DEPTH == 8 || DEPTH == 16 || DEPTH == 32 || DEPTH == 64)
      else $error("DEPTH must be 8, 16, 32 or 64");
  end

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [LW-1:0] lvl, lvl_n;
  logic [5:0]    thr;
  logic [15:0]   stat, stat_n;
  logic          is_empty, is_full, flush, wr_ok, sp_ok, rd_ok, sq_ok;
  logic [1:0]    push_n, pop_n;
  logic [7:0]    b0, b1, h0, h1;
  logic [6:0]    lvl7, lvln7;

  assign is_empty = (lvl == '0);
  assign is_full  = (lvl == FULL_LVL);
  assign flush    = cfg_wr && (cfg_wdata[14] || cfg_wdata[6]);
  assign wr_ok    = sw_wr && (legacy_mode ? (lvl <= LW'(2)) : !is_full);
  assign sp_ok    = seq_push && !sw_wr && !is_full;
  assign rd_ok    = sw_rd && !is_empty;
  assign sq_ok    = seq_pop && !sw_rd && !is_empty;
  assign push_n   = wr_ok ? (legacy_mode ? 2'd2 : 2'd1) : (sp_ok ? 2'd1 : 2'd0);
  assign pop_n    = rd_ok ? ((legacy_mode && lvl != LW'(1)) ? 2'd2 : 2'd1)
                          : (sq_ok ? 2'd1 : 2'd0);
  assign lvl_n    = lvl + LW'(push_n) - LW'(pop_n);
  assign lvl7     = 7'(lvl);
  assign lvln7    = 7'(lvl_n);

  assign b0 = !wr_ok ? seq_wdata
            : (legacy_mode && byte_order_hi) ? sw_wdata[15:8] : sw_wdata[7:0];
  assign b1 = byte_order_hi ? sw_wdata[7:0] : sw_wdata[15:8];
  assign h0 = mem[rp];
  assign h1 = mem[rp + AW'(1)];

  always_comb begin
    if (is_empty)
      sw_rdata = 16'h0000;
    else if (!legacy_mode)
      sw_rdata = {8'h00, h0};
    else if (lvl == LW'(1))
      sw_rdata = byte_order_hi ? {h0, 8'h00} : {8'h00, h0};
    else
      sw_rdata = byte_order_hi ? {h0, h1} : {h1, h0};
  end
  assign seq_rdata = is_empty ? 8'h00 : h0;

  always_ff @(posedge clk) begin
    if (push_n != 2'd0) mem[wp] <= b0;
    if (push_n == 2'd2) mem[wp + AW'(1)] <= b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      lvl <= '0;
      thr <= '0;
    end else begin
      if (cfg_wr) thr <= cfg_wdata[13:8];
      if (flush) begin
        wp  <= '0;
        rp  <= '0;
        lvl <= '0;
      end else begin
        wp  <= wp + AW'(push_n);
        rp  <= rp + AW'(pop_n);
        lvl <= lvl_n;
      end
    end
  end

  always_comb begin
    stat_n = stat & ~stat_clr;
    if (sw_wr) begin
      stat_n[F_TXUF] = 1'b0;
      if (wr_ok) stat_n[F_AERR] = 1'b0;
      else if (!legacy_mode) stat_n[F_AERR] = 1'b1;
    end
    if (sw_rd) begin
      if (is_empty) stat_n[F_AERR] = 1'b1;
      else begin
        stat_n[F_AERR] = 1'b0;
        stat_n[F_RXOV] = 1'b0;
        if (legacy_mode && lvl == LW'(1)) stat_n[F_ODD] = 1'b1;
        if (lvl_n == '0) begin
          stat_n[F_RXRDY] = 1'b0;
          stat_n[F_DRAIN] = 1'b0;
          stat_n[F_DONE]  = 1'b1;
        end else if (lvln7 <= {1'b0, thr}) begin
          stat_n[F_RXRDY] = 1'b0;
          stat_n[F_DRAIN] = 1'b1;
        end
      end
    end
    if (seq_push && !sw_wr) begin
      if (is_full) stat_n[F_RXOV] = 1'b1;
      else if (lvln7 > {1'b0, thr}) begin
        stat_n[F_RXRDY] = 1'b1;
        stat_n[F_DRAIN] = 1'b0;
      end else begin
        stat_n[F_RXRDY] = 1'b0;
        stat_n[F_DRAIN] = 1'b1;
      end
    end
    if (seq_pop && !sw_rd && is_empty) stat_n[F_TXUF] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) stat <= '0;
    else        stat <= stat_n & USED;
  end

  assign status  = stat;
  assign bufstat = {DCODE, lvl7[5:0], 2'b00, remain_count[5:0]};

  p_level_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    lvl <= FULL_LVL);

  p_full_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr && !legacy_mode && is_full && !sw_rd && !seq_pop && !flush)
    |=> (lvl == FULL_LVL) && status[F_AERR]);

  p_empty_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_rd && is_empty) |=> status[F_AERR]);

  p_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (bufstat[13:8] == 6'd0));

  p_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_pop && !sw_rd && is_empty) |=> status[F_TXUF]);

  p_push_pop_even_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_push && !sw_wr && !is_full && seq_pop && !sw_rd && !is_empty && !flush)
    |=> $stable(lvl));

  p_odd_byte_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_rd && legacy_mode && lvl == LW'(1) && !flush && !seq_push && !sw_wr)
    |=> (lvl == '0) && status[F_ODD]);
endmodule

// File: tb/thresh_byte_fifo_test.sv
module thresh_byte_fifo_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic legacy_mode = 1'b0, byte_order_hi = 1'b0;
  logic sw_wr = 1'b0, sw_rd = 1'b0, seq_push = 1'b0, seq_pop = 1'b0, cfg_wr = 1'b0;
  logic [15:0] sw_wdata = '0, cfg_wdata = '0, stat_clr = '0, remain_count = '0;
  logic [7:0] seq_wdata = '0;
  logic [15:0] sw_rdata, status, bufstat, rd64, st64, bs64;
  logic [7:0] seq_rdata, sq64;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  thresh_byte_fifo #(.DEPTH(8)) uut (
    .clk, .rst_n, .legacy_mode, .byte_order_hi, .sw_wr, .sw_wdata, .sw_rd,
    .sw_rdata, .seq_push, .seq_wdata, .seq_pop, .seq_rdata, .cfg_wr, .cfg_wdata,
    .stat_clr, .remain_count, .status, .bufstat);

  thresh_byte_fifo #(.DEPTH(64)) uut64 (
    .clk, .rst_n, .legacy_mode(1'b0), .byte_order_hi(1'b0), .sw_wr(1'b0),
    .sw_wdata(16'h0), .sw_rd(1'b0), .sw_rdata(rd64), .seq_push(1'b0),
    .seq_wdata(8'h0), .seq_pop(1'b0), .seq_rdata(sq64), .cfg_wr(1'b0),
    .cfg_wdata(16'h0), .stat_clr(16'h0), .remain_count(16'h0), .status(st64),
    .bufstat(bs64));

  // {op, data, expected read byte, expected level}; op 0 wr, 1 rd, 2 seq push, 3 seq pop
  localparam logic [24:0] VEC [20] = '{
    {2'd0, 8'h11, 8'h00, 7'd1}, {2'd0, 8'h22, 8'h00, 7'd2},
    {2'd2, 8'h33, 8'h00, 7'd3}, {2'd1, 8'h00, 8'h11, 7'd2},
    {2'd3, 8'h00, 8'h22, 7'd1}, {2'd0, 8'h44, 8'h00, 7'd2},
    {2'd1, 8'h00, 8'h33, 7'd1}, {2'd1, 8'h00, 8'h44, 7'd0},
    {2'd0, 8'hA0, 8'h00, 7'd1}, {2'd0, 8'hA1, 8'h00, 7'd2},
    {2'd0, 8'hA2, 8'h00, 7'd3}, {2'd0, 8'hA3, 8'h00, 7'd4},
    {2'd0, 8'hA4, 8'h00, 7'd5}, {2'd2, 8'hA5, 8'h00, 7'd6},
    {2'd1, 8'h00, 8'hA0, 7'd5}, {2'd3, 8'h00, 8'hA1, 7'd4},
    {2'd1, 8'h00, 8'hA2, 7'd3}, {2'd1, 8'h00, 8'hA3, 7'd2},
    {2'd3, 8'h00, 8'hA4, 7'd1}, {2'd1, 8'h00, 8'hA5, 7'd0}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    sw_wr = 0; sw_rd = 0; seq_push = 0; seq_pop = 0; cfg_wr = 0; stat_clr = '0;
  endtask

  task automatic do_reset();
    idle();
    rst_n = 0;
    tick(); tick();
    rst_n = 1;
  endtask

  task automatic wr(input logic [15:0] d);
    sw_wr = 1; sw_wdata = d; tick(); idle();
  endtask

  task automatic rd_expect(input string req, input logic [15:0] exp);
    sw_rd = 1; #5; check(req, sw_rdata, exp); tick(); idle();
  endtask

  task automatic spush(input logic [7:0] d);
    seq_push = 1; seq_wdata = d; tick(); idle();
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    // R12 reset state, R7 depth codes
    check("R12 status", status, 16'h0000);
    check("R12 bufstat", bufstat, 16'h0000);
    check("R7 depth64 code", bs64, 16'hC000);

    // R10 table walk: order across pointer wrap
    foreach (VEC[i]) begin
      case (VEC[i][24:23])
        2'd0: begin sw_wr = 1; sw_wdata = {8'h00, VEC[i][22:15]}; end
        2'd1: begin sw_rd = 1; #5; check("R2 table read", sw_rdata, {8'h00, VEC[i][14:7]}); end
        2'd2: begin seq_push = 1; seq_wdata = VEC[i][22:15]; end
        default: begin seq_pop = 1; #5; check("R5 table pop", {8'h00, seq_rdata}, {8'h00, VEC[i][14:7]}); end
      endcase
      tick(); idle();
      check("R10 table level", {10'h0, bufstat[13:8]}, {9'h0, VEC[i][6:0]});
    end

    do_reset();
    // R2 empty read
    rd_expect("R2 empty read data", 16'h0000);
    check("R2 empty read aerr", {15'h0, status[7]}, 16'h1);
    // R1 write clears aerr, fill to full
    wr(16'h0010);
    check("R1 write clears aerr", {15'h0, status[7]}, 16'h0);
    for (int k = 1; k < 8; k++) wr(16'(k));
    remain_count = 16'h012A;
    #1;
    check("R7 bufstat full", bufstat, 16'h082A);
    wr(16'h00EE);
    check("R1 full write aerr", {15'h0, status[7]}, 16'h1);
    check("R1 full write level", {10'h0, bufstat[13:8]}, 16'd8);
    spush(8'hEF);
    check("R4 overrun flag", {15'h0, status[11]}, 16'h1);
    rd_expect("R1 oldest byte kept", 16'h0010);
    check("R2 read clears overrun", {15'h0, status[11]}, 16'h0);
    check("R2 read clears aerr", {15'h0, status[7]}, 16'h0);

    // R6 flush with threshold 3
    cfg_wr = 1; cfg_wdata = 16'h0340; tick(); idle();
    check("R6 flush level", {10'h0, bufstat[13:8]}, 16'd0);

    // R4 threshold on sequencer pushes
    spush(8'h01); spush(8'h02); spush(8'h03);
    check("R4 at threshold", status & 16'h2008, 16'h2000);
    spush(8'h04); spush(8'h05);
    check("R4 above threshold", status & 16'h2008, 16'h0008);
    // R3 threshold on software pops
    rd_expect("R3 pop 1", 16'h0001);
    check("R3 still ready at 4", status & 16'h2008, 16'h0008);
    rd_expect("R3 pop 2", 16'h0002);
    check("R3 drain at 3", status & 16'h2008, 16'h2000);
    rd_expect("R3 pop 3", 16'h0003);
    rd_expect("R3 pop 4", 16'h0004);
    rd_expect("R3 pop 5", 16'h0005);
    check("R3 empty flags", status & 16'h200C, 16'h0004);

    // R11 write-one-to-clear
    stat_clr = 16'h0004; tick(); idle();
    check("R11 clear done bit", {15'h0, status[2]}, 16'h0);

    // R5 underflow and its clear
    seq_pop = 1; #5;
    check("R5 empty pop data", {8'h0, seq_rdata}, 16'h0000);
    tick(); idle();
    check("R5 underflow flag", {15'h0, status[10]}, 16'h1);
    wr(16'h0055);
    check("R5 write clears underflow", {15'h0, status[10]}, 16'h0);
    wr(16'h0066);
    // R10 simultaneous push and pop
    seq_push = 1; seq_wdata = 8'h77; seq_pop = 1; #5;
    check("R10 pop data", {8'h0, seq_rdata}, 16'h0055);
    tick(); idle();
    check("R10 level unchanged", {10'h0, bufstat[13:8]}, 16'd2);
    rd_expect("R10 order 1", 16'h0066);
    rd_expect("R10 order 2", 16'h0077);

    // R8 legacy writes
    legacy_mode = 1; byte_order_hi = 0;
    wr(16'hBBAA);
    byte_order_hi = 1;
    wr(16'hCCDD);
    check("R8 legacy level", {10'h0, bufstat[13:8]}, 16'd4);
    wr(16'h1234);
    check("R8 ignored write", {10'h0, bufstat[13:8]}, 16'd4);
    // R9 legacy reads
    byte_order_hi = 0;
    rd_expect("R9 low-first read", 16'hBBAA);
    byte_order_hi = 1;
    rd_expect("R9 high-first read", 16'hCCDD);
    check("R9 level after reads", {10'h0, bufstat[13:8]}, 16'd0);
    check("R9 no odd flag yet", {15'h0, status[15]}, 16'h0);
    legacy_mode = 0;
    wr(16'h005A);
    legacy_mode = 1;
    rd_expect("R9 single byte high-first", 16'h5A00);
    check("R9 odd flag", {15'h0, status[15]}, 16'h1);
    check("R9 emptied", {10'h0, bufstat[13:8]}, 16'd0);
    legacy_mode = 0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule